// File: doc/BRIEF.md
# Reset Cause and Low-Speed Oscillator Control/Status Register

This block is a single bus-mapped control/status word with two jobs. First, it keeps a sticky record of which hardware event caused the most recent chip reset. There are seven sources: the external reset pin, brown-out, software request, independent watchdog, window watchdog, illegal low-power mode entry, and option-byte load. Each source delivers a one-cycle pulse that sets its flag. A single write-one command clears all seven flags together. The flags sit in an always-on domain. The general reset `rst` leaves them alone, and only the power-on reset `por` initialises them.

Second, it manages the enable and ready handshake of a low-speed internal oscillator. The oscillator request sent to the analog side is the OR of a software enable bit and three requests from other peripherals: the clock-security monitor, the independent watchdog and the real-time clock. Oscillator cycles arrive as `osc_tick` pulses in the `clk` domain. A tick is counted only after the cycle in which the sequencer first sees the new request level. The ready bit rises after a start-up count of ticks with the request high. It falls after a stop count of ticks with the request low.

The register sits at one address, `REG_ADDR`, and has this layout:
- bit 0: software oscillator enable (read/write).
- bit 1: oscillator ready (read-only).
- bit 2: clear-flags command (write-one, always reads 0).
- bits 8 to 14: reset-cause flags, in this order: pin, brown-out, software, independent watchdog, window watchdog, low-power, option-byte. These bits are read-only.

All other bits read 0.

Top module: `rstcause_osc_csr`

## Requirements
- R1: A pulse on `rst_evt[i]` sets flag i, which then reads at bit 8+i. The flag stays set through any number of `rst` assertions.
- R2: A write to `REG_ADDR` with bit 2 = 1 clears all seven flags on that edge. A write with bit 2 = 0 leaves the flags unchanged.
- R3: A source event in the same cycle as a clear command leaves that flag set.
- R4: `por` clears all flags, the enable bit, the ready sequencer and the read data. After `por`, the register reads 0.
- R5: Bit 0 is read/write through the bus. `rst` clears it.
- R6: `osc_on` is high whenever the enable bit or any of `css_req`, `iwdg_req` or `rtc_req` is high, and low otherwise.
- R7: With the request held high, `osc_rdy` rises right after the edge that counts the START_TICKS-th tick (default 3). It stays low before that tick.
- R8: After the request falls, `osc_rdy` stays high until the STOP_TICKS-th counted tick (default 3), then falls. If the request returns during this countdown, `osc_rdy` stays high.
- R9: `osc_rdy` can become 1 while the enable bit is 0, driven by a peripheral request alone.
- R10: Writes to the ready bit and the flag bits have no effect. Bit 2 and all unmapped bits always read 0.
- R11: `rd_data` carries the register value in the cycle after a read of `REG_ADDR`. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | General synchronous reset, active high; does not touch flags |
| por | input | 1 | Power-on reset, active high; clears everything |
| rst_evt | input | 7 | One pulse per reset source, index order as bits 8..14 |
| css_req | input | 1 | Oscillator request from the clock-security monitor |
| iwdg_req | input | 1 | Oscillator request from the independent watchdog |
| rtc_req | input | 1 | Oscillator request from the real-time clock |
| osc_tick | input | 1 | One pulse per oscillator clock cycle |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data, one cycle after the strobe |
| osc_on | output | 1 | Oscillator request to the analog side |
| osc_rdy | output | 1 | Oscillator ready |

## Verification
The bench targets the collision of a source event with a clear command. A design that gives the clear priority would lose the reset cause of that very cycle. It also checks that `rst` does not wipe the flags; a design that tied them to the general reset would report nothing after a watchdog reset. The stop countdown is probed one tick short of its end, to catch a design that drops ready too early. The bench also re-raises a request during the countdown, to catch a sequencer that drops ready anyway. Writes of 1 to the ready bit and the flag bits check that no read-only state is writable from the bus.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_SRC   = 7;
    localparam int BIT_EN    = 0;
    localparam int BIT_RDY   = 1;
    localparam int BIT_CLR   = 2;
    localparam int BIT_FLAG0 = 8;

    typedef enum logic [2:0] {
        SRC_PIN   = 3'd0,
        SRC_BOR   = 3'd1,
        SRC_SW    = 3'd2,
        SRC_IWDG  = 3'd3,
        SRC_WWDG  = 3'd4,
        SRC_LPWR  = 3'd5,
        SRC_OPTLD = 3'd6
    } rst_src_e;

    typedef enum logic [1:0] {
        OSC_OFF   = 2'd0,
        OSC_START = 2'd1,
        OSC_READY = 2'd2,
        OSC_STOP  = 2'd3
    } osc_state_e;

    typedef struct packed {
        logic               en;
        logic               rdy;
        logic [NUM_SRC-1:0] flags;
    } csr_view_t;

    function automatic logic [DATA_W-1:0] pack_csr(input csr_view_t v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_EN]  = v.en;
        w[BIT_RDY] = v.rdy;
        w[BIT_FLAG0 +: NUM_SRC] = v.flags;
        return w;
    endfunction

endpackage

// File: rtl/rstcause_flags.sv
module rstcause_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         por,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (por)
                flags[i] <= 1'b0;
            else if (evt[i])
                flags[i] <= 1'b1;
            else if (clr)
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/osc_ready_seq.sv
module osc_ready_seq
    import rstcause_pkg::*;
#(
    parameter int START_TICKS = 3,
    parameter int STOP_TICKS  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic req,
    input  logic tick,
    output logic ready
);
    localparam int MAXT  = (START_TICKS > STOP_TICKS) ? START_TICKS : STOP_TICKS;
    localparam int CNT_W = $clog2(MAXT + 1);
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_TICKS - 1);
    localparam logic [CNT_W-1:0] STOP_LAST  = CNT_W'(STOP_TICKS - 1);

    osc_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || por) begin
            state_q <= OSC_OFF;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                OSC_OFF: begin
                    cnt_q <= '0;
                    if (req) state_q <= OSC_START;
                end
                OSC_START: begin
                    if (!req) begin
                        state_q <= OSC_OFF;
                        cnt_q   <= '0;
                    end else if (tick) begin
                        if (cnt_q == START_LAST) begin
                            state_q <= OSC_READY;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                OSC_READY: begin
                    cnt_q <= '0;
                    if (!req) state_q <= OSC_STOP;
                end
                OSC_STOP: begin
                    if (req) begin
                        state_q <= OSC_READY;
                        cnt_q   <= '0;
                    end else if (tick) begin
                        if (cnt_q == STOP_LAST) begin
                            state_q <= OSC_OFF;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= OSC_OFF;
            endcase
        end
    end

    assign ready = (state_q == OSC_READY) || (state_q == OSC_STOP);
endmodule

// File: rtl/csr_regif.sv
module csr_regif
    import rstcause_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  csr_view_t         hw_view,
    output logic [DATA_W-1:0] rd_data,
    output logic              sw_en,
    output logic              clr_cmd
);
    logic wr_hit;
    logic rd_hit;

    assign wr_hit  = wr_en && (wr_addr == REG_ADDR);
    assign rd_hit  = rd_en && (rd_addr == REG_ADDR);
    assign clr_cmd = wr_hit && wr_data[BIT_CLR];

    always_ff @(posedge clk) begin
        if (rst || por)
            sw_en <= 1'b0;
        else if (wr_hit)
            sw_en <= wr_data[BIT_EN];
    end

    always_ff @(posedge clk) begin
        if (por)
            rd_data <= '0;
        else if (rd_hit)
            rd_data <= pack_csr(hw_view);
        else
            rd_data <= '0;
    end
endmodule

// File: rtl/rstcause_osc_csr.sv
module rstcause_osc_csr
    import rstcause_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h10,
    parameter int                START_TICKS = 3,
    parameter int                STOP_TICKS  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic [6:0]        rst_evt,
    input  logic              css_req,
    input  logic              iwdg_req,
    input  logic              rtc_req,
    input  logic              osc_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              osc_on,
    output logic              osc_rdy
);
    logic               sw_en;
    logic               clr_cmd;
    logic [NUM_SRC-1:0] flags_q;
    csr_view_t          view;

    rstcause_flags #(.N(NUM_SRC)) u_flags (
        .clk   (clk),
        .por   (por),
        .evt   (rst_evt),
        .clr   (clr_cmd),
        .flags (flags_q)
    );

    assign osc_on = sw_en | css_req | iwdg_req | rtc_req;

    osc_ready_seq #(
        .START_TICKS (START_TICKS),
        .STOP_TICKS  (STOP_TICKS)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .por   (por),
        .req   (osc_on),
        .tick  (osc_tick),
        .ready (osc_rdy)
    );

    always_comb begin
        view.en    = sw_en;
        view.rdy   = osc_rdy;
        view.flags = flags_q;
    end

    csr_regif #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regif (
        .clk     (clk),
        .rst     (rst),
        .por     (por),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .hw_view (view),
        .rd_data (rd_data),
        .sw_en   (sw_en),
        .clr_cmd (clr_cmd)
    );
endmodule

// File: rtl/rstcause_osc_csr_chk.sv
module rstcause_osc_csr_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
    input logic              clk,
    input logic              rst,
    input logic              por,
    input logic [6:0]        rst_evt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [31:0]       rd_data,
    input logic              osc_on,
    input logic              osc_tick,
    input logic              osc_rdy,
    input logic [6:0]        flags
);
    logic bus_clear;
    assign bus_clear = wr_en && (wr_addr == REG_ADDR) && wr_data[2];

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (por)
        !bus_clear |=> ((flags & $past(flags)) == $past(flags)));                 // R1

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (por)
        (rst_evt != 7'd0) |=> ((flags & $past(rst_evt)) == $past(rst_evt)));    // R3

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (por)
        (bus_clear && rst_evt == 7'd0) |=> (flags == 7'd0));                     // R2

    AST_RDY_RISE_REQ: assert property (@(posedge clk) disable iff (rst || por)
        $rose(osc_rdy) |-> ($past(osc_on) && $past(osc_tick)));                  // R7

    AST_RDY_FALL_TICK: assert property (@(posedge clk) disable iff (rst || por)
        $fell(osc_rdy) |-> ($past(osc_tick) && !$past(osc_on)));                 // R8

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (por)
        (rd_data[2] == 1'b0) && (rd_data[7:3] == 5'd0) && (rd_data[31:15] == 17'd0)); // R10
endmodule

bind rstcause_osc_csr rstcause_osc_csr_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .por      (por),
    .rst_evt  (rst_evt),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .osc_on   (osc_on),
    .osc_tick (osc_tick),
    .osc_rdy  (osc_rdy),
    .flags    (flags_q)
);

// File: tb/rstcause_osc_csr_tb.sv
module rstcause_osc_csr_tb;
    localparam logic [7:0] RA = 8'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por = 1'b1;
    logic [6:0]  rst_evt = '0;
    logic        css_req = 1'b0, iwdg_req = 1'b0, rtc_req = 1'b0, osc_tick = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_addr = RA, rd_addr = RA;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        osc_on, osc_rdy;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rstcause_osc_csr u_dut (
        .clk(clk), .rst(rst), .por(por), .rst_evt(rst_evt),
        .css_req(css_req), .iwdg_req(iwdg_req), .rtc_req(rtc_req),
        .osc_tick(osc_tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .osc_on(osc_on), .osc_rdy(osc_rdy)
    );

    // {evt[6:0], wr, clr_bit, expected flags[6:0]}
    localparam logic [15:0] VEC [9] = '{
        {7'b0000001, 1'b0, 1'b0, 7'b0000001},
        {7'b0000100, 1'b0, 1'b0, 7'b0000101},
        {7'b0000000, 1'b1, 1'b1, 7'b0000000},
        {7'b1000000, 1'b0, 1'b0, 7'b1000000},
        {7'b0010000, 1'b1, 1'b1, 7'b0010000},
        {7'b0000000, 1'b1, 1'b0, 7'b0010000},
        {7'b0101010, 1'b0, 1'b0, 7'b0111010},
        {7'b1111111, 1'b1, 1'b1, 7'b1111111},
        {7'b0000000, 1'b1, 1'b1, 7'b0000000}
    };

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_en = 1'b1; rd_addr = a;
        cyc();
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic tick();
        osc_tick = 1'b1;
        cyc();
        osc_tick = 1'b0;
        cyc();
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        cyc(); cyc();
        rst = 1'b0; por = 1'b0;
        cyc();
        rd(RA, r);
        check("R4 reset state", r, 32'h0);
        check("R6 osc_on idle", {31'd0, osc_on}, 32'd0);

        for (int i = 0; i < 9; i++) begin
            rst_evt = VEC[i][15:9];
            if (VEC[i][8]) begin
                wr_en = 1'b1; wr_addr = RA; wr_data = {29'd0, VEC[i][7], 2'b00};
            end
            cyc();
            rst_evt = '0; wr_en = 1'b0; wr_data = '0;
            rd(RA, r);
            check("R1 R2 R3 flag vector", {25'd0, r[14:8]}, {25'd0, VEC[i][6:0]});
        end

        // R1: general reset keeps flags
        rst_evt = 7'b0001000; cyc(); rst_evt = '0;
        rst = 1'b1; cyc(); cyc(); rst = 1'b0; cyc();
        rd(RA, r);
        check("R1 flags survive rst", r, 32'h0000_0800);

        // R10: writes to read-only bits ignored, clear bit reads 0
        wr(RA, 32'hFFFF_7F02);
        rd(RA, r);
        check("R10 ro bits ignore write", r, 32'h0000_0800);

        // R4: por clears flags
        por = 1'b1; cyc(); por = 1'b0; cyc();
        rd(RA, r);
        check("R4 por clears flags", r, 32'h0);

        // R5 / R6: enable readback and osc_on
        wr(RA, 32'h1);
        rd(RA, r);
        check("R5 enable reads 1", r & 32'h1, 32'h1);
        check("R6 osc_on from enable", {31'd0, osc_on}, 32'd1);

        // R7: ready after 3 ticks
        cyc();
        tick(); tick();
        check("R7 not ready after 2 ticks", {31'd0, osc_rdy}, 32'd0);
        tick();
        check("R7 ready after 3 ticks", {31'd0, osc_rdy}, 32'd1);
        rd(RA, r);
        check("R7 ready bit in register", r, 32'h3);

        // R8: fall after 3 ticks
        wr(RA, 32'h0);
        cyc();
        tick(); tick();
        check("R8 still ready after 2 stop ticks", {31'd0, osc_rdy}, 32'd1);
        tick();
        check("R8 ready low after 3 stop ticks", {31'd0, osc_rdy}, 32'd0);
        check("R6 osc_on low", {31'd0, osc_on}, 32'd0);

        // R9: peripheral request alone
        rtc_req = 1'b1; cyc();
        check("R6 osc_on from rtc", {31'd0, osc_on}, 32'd1);
        tick(); tick(); tick();
        check("R9 ready without enable", {31'd0, osc_rdy}, 32'd1);
        rd(RA, r);
        check("R9 register en=0 rdy=1", r, 32'h2);

        // R8: request returns during countdown
        rtc_req = 1'b0; cyc();
        tick();
        iwdg_req = 1'b1; cyc();
        tick(); tick(); tick();
        check("R8 ready held on re-request", {31'd0, osc_rdy}, 32'd1);
        iwdg_req = 1'b0; cyc();
        tick(); tick(); tick();
        check("R8 ready low after final stop", {31'd0, osc_rdy}, 32'd0);

        // R11: other address reads 0
        rst_evt = 7'b0000010; cyc(); rst_evt = '0;
        rd(8'h14, r);
        check("R11 unmapped address", r, 32'h0);
        rd(RA, r);
        check("R11 mapped address", r, 32'h0000_0200);

        // R5: rst clears enable
        css_req = 1'b1;
        wr(RA, 32'h1);
        rst = 1'b1; cyc(); rst = 1'b0; cyc();
        rd(RA, r);
        check("R5 rst clears enable", r & 32'h1, 32'h0);
        check("R6 osc_on from css", {31'd0, osc_on}, 32'd1);
        css_req = 1'b0;

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule